// File: doc/BRIEF.md
# DRAM Access Cycle Classifier

This block sits inside a simplified model of an asynchronous DRAM device. It samples the active-low row strobe, column strobe and write-enable on a fast system clock and sorts every column access into one of four kinds. The kind depends on where the write-enable falling edge lands relative to the column-strobe falling edge. The four kinds are a plain read, an early write, a read-modify-write, and an access whose output state cannot be relied on. Setup margins are whole clock-edge counts, and each one is set by its own parameter.

The classification drives three things. It decides whether the data output is ever enabled. It decides on which sampled edge the write data is taken for the array, which is the column-strobe fall for an early write and the write-enable fall for a read-modify-write. It also sets a two-bit type code that the rest of the model can read while the column strobe stays low. Edge counts use sampled edges: a strobe that fell at edge k has been low for m-k edges when it is seen at edge m.

Top module: `dramWrCycleClassifier`

## Requirements
- R1: While `rstN` is low, `outEn`, `wrStrobe` and `typeValid` are 0 and `cycleType` is 2'b00.
- R2: The column strobe may be sampled falling while the row strobe is low and write-enable has been low for at least `WE_SETUP` edges. In that case the access is an early write: `cycleType` becomes 2'b01 with `typeValid` after that edge, a single `wrStrobe` pulse carries the `dataIn` sampled at that edge, and `outEn` stays 0 for the whole access.
- R3: If write-enable is low at the column-strobe fall but has been low for fewer than `WE_SETUP` edges (this includes falling on the same edge), `cycleType` becomes 2'b11, no `wrStrobe` is issued and `outEn` stays 0.
- R4: If write-enable is high at the column-strobe fall (row strobe low), the access is a read: `outEn` is 1 and `cycleType` is 2'b00 with `typeValid` 1 from that edge until the column strobe rises.
- R5: During a read, write-enable may fall at an edge that is at least `CAS_TO_WE` edges after the column-strobe fall and at least `RAS_TO_WE` edges after the row-strobe fall. The access then becomes a read-modify-write: `cycleType` becomes 2'b10, one `wrStrobe` pulse carries the `dataIn` of that edge, and `outEn` stays 1.
- R6: During a read, if write-enable falls before either of those margins is reached, `cycleType` becomes 2'b11, no `wrStrobe` is issued and `outEn` drops to 0 after that edge.
- R7: After any edge at which the column or row strobe is sampled high, `outEn` and `typeValid` are 0 and `cycleType` is 2'b00.
- R8: A column-strobe fall sampled while the row strobe is high starts no access. A row-strobe fall that follows while the column strobe stays low starts none either.
- R9: Once an access is classified as early write, read-modify-write or indeterminate, further write-enable edges during the same column-low period change nothing, and each access issues at most one `wrStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write-enable, active low |
| dataIn | input | DATA_W | Write data bus |
| outEn | output | 1 | Data-output enable |
| wrStrobe | output | 1 | One-cycle write pulse to the array |
| wrData | output | DATA_W | Write data captured on the chosen edge |
| cycleType | output | 2 | 00 read, 01 early write, 10 read-modify-write, 11 indeterminate |
| typeValid | output | 1 | `cycleType` is meaningful |

## Verification
The hardest cases to reach sit exactly on the margin boundaries. Write-enable has to fall exactly `WE_SETUP` edges before the column strobe, or exactly `CAS_TO_WE` and `RAS_TO_WE` edges after the two strobe falls, with a miss by one edge on each side. The stimulus builds every access from a schedule of edge indices, one for each strobe fall and rise, so each ordering and each off-by-one is placed on a known edge. Write-enable bounces after the decision, and strobes that fall in the wrong order, are added as extra schedule entries and as directed sequences.

// File: rtl/dramcls_pkg.sv
package dramcls_pkg;

  typedef enum logic [1:0] {
    CODE_READ  = 2'b00,
    CODE_EARLY = 2'b01,
    CODE_RMW   = 2'b10,
    CODE_INDET = 2'b11
  } cycleCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EARLY,
    ST_RMW,
    ST_INDET
  } accState_e;

  typedef struct packed {
    logic       capture;
    logic       oeSet;
    logic       oeClr;
    logic       codeLoad;
    cycleCode_e code;
    logic       codeClr;
  } ctrlStrobes_t;

endpackage

// File: rtl/strobeTimer.sv
module strobeTimer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowN,
  output logic [CNT_W-1:0] lowCnt
);
  localparam logic [CNT_W-1:0] SAT = '1;

  // Counts sampled edges spent low; cleared while the strobe is high.
  always_ff @(posedge clk) begin
    if (!rstN)             lowCnt <= '0;
    else if (lowN)         lowCnt <= '0;
    else if (lowCnt != SAT) lowCnt <= lowCnt + 1'b1;
  end
endmodule

// File: rtl/wrCycleCtrl.sv
module wrCycleCtrl
  import dramcls_pkg::*;
#(
  parameter int WE_SETUP  = 2,
  parameter int RAS_TO_WE = 4,
  parameter int CAS_TO_WE = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rasN,
  input  logic         casN,
  input  logic         weN,
  output ctrlStrobes_t strobes
);
  localparam int MAX_A = (WE_SETUP > RAS_TO_WE) ? WE_SETUP : RAS_TO_WE;
  localparam int MAX_P = (MAX_A > CAS_TO_WE) ? MAX_A : CAS_TO_WE;
  localparam int CNT_W = $clog2(MAX_P + 2);
  localparam int NSTB  = 3;
  localparam logic [CNT_W-1:0] LIM_WS  = CNT_W'(WE_SETUP);
  localparam logic [CNT_W-1:0] LIM_RAS = CNT_W'(RAS_TO_WE);
  localparam logic [CNT_W-1:0] LIM_CAS = CNT_W'(CAS_TO_WE);

  logic [NSTB-1:0]  stbN;
  logic [CNT_W-1:0] lowCnt [NSTB];
  logic             casPrevN, wePrevN;
  logic             casFall, weFall;
  accState_e        state, nxtState;

  assign stbN = {weN, casN, rasN};

  for (genvar i = 0; i < NSTB; i++) begin : g_tmr
    strobeTimer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rstN  (rstN),
      .lowN  (stbN[i]),
      .lowCnt(lowCnt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      casPrevN <= 1'b1;
      wePrevN  <= 1'b1;
      state    <= ST_IDLE;
    end else begin
      casPrevN <= casN;
      wePrevN  <= weN;
      state    <= nxtState;
    end
  end

  assign casFall = !casN && casPrevN;
  assign weFall  = !weN && wePrevN;

  always_comb begin
    strobes  = '0;
    nxtState = state;
    if (casN || rasN) begin
      nxtState        = ST_IDLE;
      strobes.oeClr   = 1'b1;
      strobes.codeClr = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (casFall) begin
            strobes.codeLoad = 1'b1;
            if (!weN) begin
              if (lowCnt[2] >= LIM_WS) begin
                nxtState        = ST_EARLY;
                strobes.capture = 1'b1;
                strobes.code    = CODE_EARLY;
              end else begin
                nxtState     = ST_INDET;
                strobes.code = CODE_INDET;
              end
            end else begin
              nxtState      = ST_READ;
              strobes.oeSet = 1'b1;
              strobes.code  = CODE_READ;
            end
          end
        end
        ST_READ: begin
          if (weFall) begin
            strobes.codeLoad = 1'b1;
            if (lowCnt[1] >= LIM_CAS && lowCnt[0] >= LIM_RAS) begin
              nxtState        = ST_RMW;
              strobes.capture = 1'b1;
              strobes.code    = CODE_RMW;
            end else begin
              nxtState      = ST_INDET;
              strobes.oeClr = 1'b1;
              strobes.code  = CODE_INDET;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  decided_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_EARLY, ST_RMW, ST_INDET}) && !casN && !rasN |-> !strobes.capture);
endmodule

// File: rtl/wrCycleData.sv
module wrCycleData
  import dramcls_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic              outEn,
  output logic              wrStrobe,
  output logic [DATA_W-1:0] wrData,
  output logic [1:0]        cycleType,
  output logic              typeValid
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outEn     <= 1'b0;
      wrStrobe  <= 1'b0;
      wrData    <= '0;
      cycleType <= CODE_READ;
      typeValid <= 1'b0;
    end else begin
      wrStrobe <= strobes.capture;
      if (strobes.capture) wrData <= dataIn;
      if (strobes.oeClr)      outEn <= 1'b0;
      else if (strobes.oeSet) outEn <= 1'b1;
      if (strobes.codeClr) begin
        typeValid <= 1'b0;
        cycleType <= CODE_READ;
      end else if (strobes.codeLoad) begin
        typeValid <= 1'b1;
        cycleType <= strobes.code;
      end
    end
  end

  // R2
  early_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    typeValid && cycleType == CODE_EARLY |-> !outEn);
  // R3
  indet_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    typeValid && cycleType == CODE_INDET |-> !outEn);
  // R5
  strobe_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> typeValid && (cycleType == CODE_EARLY || cycleType == CODE_RMW));
endmodule

// File: rtl/dramWrCycleClassifier.sv
module dramWrCycleClassifier
  import dramcls_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WE_SETUP  = 2,
  parameter int RAS_TO_WE = 4,
  parameter int CAS_TO_WE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              outEn,
  output logic              wrStrobe,
  output logic [DATA_W-1:0] wrData,
  output logic [1:0]        cycleType,
  output logic              typeValid
);
  ctrlStrobes_t strobes;

  wrCycleCtrl #(
    .WE_SETUP (WE_SETUP),
    .RAS_TO_WE(RAS_TO_WE),
    .CAS_TO_WE(CAS_TO_WE)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rasN   (rasN),
    .casN   (casN),
    .weN    (weN),
    .strobes(strobes)
  );

  wrCycleData #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .outEn    (outEn),
    .wrStrobe (wrStrobe),
    .wrData   (wrData),
    .cycleType(cycleType),
    .typeValid(typeValid)
  );

  // R7
  cas_high_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    casN |=> !outEn && !typeValid);
  // R8
  ras_high_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    rasN |=> !outEn && !typeValid);
  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);
endmodule

// File: tb/tb_dramWrCycleClassifier.sv
module tb_dramWrCycleClassifier;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int WS = 2, RW = 4, CW = 2;
  localparam int NV = 11;
  // {casFallEdge, weFallEdge, weSecondFallEdge, casRiseEdge}; -1 = none
  localparam int VEC [NV][4] = '{
    '{2, -1, -1, 6}, '{4, 1, -1, 7}, '{4, 2, -1, 7}, '{4, 3, -1, 7},
    '{3, 3, -1, 6},  '{2, 5, -1, 8}, '{2, 4, -1, 7}, '{3, 4, -1, 7},
    '{1, 3, -1, 6},  '{2, 5, 7, 10}, '{4, 1, 6, 9}
  };

  logic clk = 1'b0, rstN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [DW-1:0] dataIn = '0;
  logic outEn, wrStrobe, typeValid;
  logic [DW-1:0] wrData;
  logic [1:0] cycleType;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dramWrCycleClassifier #(.DATA_W(DW), .WE_SETUP(WS), .RAS_TO_WE(RW), .CAS_TO_WE(CW)) dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .dataIn(dataIn),
    .outEn(outEn), .wrStrobe(wrStrobe), .wrData(wrData),
    .cycleType(cycleType), .typeValid(typeValid));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w, input logic [DW-1:0] d);
    rasN = r; casN = c; weN = w; dataIn = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runVec(input int c, input int w, input int w2, input int e);
    int expCode, expCap, oeErr, capCnt, capEdge, capDat, endCode, endValid, endOe;
    string req;
    bit oeExp, weLow;
    if (w < 0) begin expCode = 0; expCap = -1; req = "R4"; end
    else if (w <= c) begin
      if (c - w >= WS) begin expCode = 1; expCap = c; req = "R2"; end
      else begin expCode = 3; expCap = -1; req = "R3"; end
    end else begin
      if (w - c >= CW && w >= RW) begin expCode = 2; expCap = w; req = "R5"; end
      else begin expCode = 3; expCap = -1; req = "R6"; end
    end
    if (w2 >= 0) req = "R9";
    oeErr = 0; capCnt = 0; capEdge = -1; capDat = 0;
    endCode = 0; endValid = 0; endOe = 0;
    step(1'b1, 1'b1, 1'b1, 8'h00);
    for (int t = 0; t <= e + 1; t++) begin
      weLow = (w >= 0) && t >= w && t < e && !(w2 >= 0 && t == w2 - 1);
      step((t <= e) ? 1'b0 : 1'b1, (t >= c && t < e) ? 1'b0 : 1'b1,
           weLow ? 1'b0 : 1'b1, DW'(8'h40 + t));
      if (expCode == 0 || expCode == 2) oeExp = (t >= c && t < e);
      else if (expCode == 3 && w > c)   oeExp = (t >= c && t < w);
      else                              oeExp = 1'b0;
      if (outEn !== oeExp) oeErr++;
      if (wrStrobe) begin capCnt++; if (capEdge < 0) begin capEdge = t; capDat = int'(wrData); end end
      if (t == e - 1) endCode = int'(cycleType) + (typeValid ? 4 : 0);
      if (t == e) begin endValid = int'(typeValid); endOe = int'(outEn); end
    end
    check(oeErr == 0, req, "outEn mismatching cycles", oeErr, 0);
    check(endCode == expCode + 4, req, "type code+valid*4", endCode, expCode + 4);
    check(capCnt == (expCap >= 0 ? 1 : 0) && capEdge == expCap, req, "write strobe edge",
          capEdge, expCap);
    if (expCap >= 0) check(capDat == 8'h40 + expCap, req, "captured data", capDat, 8'h40 + expCap);
    check(endValid == 0 && endOe == 0, "R7", "valid/outEn after CAS rise", endValid + endOe, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sawStrobe, sawOe, sawValid;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!outEn && !wrStrobe && !typeValid && cycleType == 2'b00, "R1", "reset outputs",
          {outEn, wrStrobe, typeValid, cycleType}, 0);
    rstN = 1'b1;
    step(1'b1, 1'b1, 1'b1, 8'h00);

    for (int v = 0; v < NV; v++) runVec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R7: RAS rises while CAS still low
    step(1'b0, 1'b1, 1'b1, 8'h00);
    step(1'b0, 1'b1, 1'b1, 8'h00);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    check(outEn && typeValid && cycleType == 2'b00, "R4", "read started", outEn, 1);
    step(1'b1, 1'b0, 1'b1, 8'h00);
    check(!outEn && !typeValid, "R7", "RAS rise clears outEn/valid", outEn + typeValid, 0);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check(!outEn && !typeValid && !wrStrobe, "R8", "no restart with CAS held low",
          outEn + typeValid + wrStrobe, 0);
    step(1'b1, 1'b1, 1'b1, 8'h00);

    // R8: CAS falls before RAS
    sawStrobe = 0; sawOe = 0; sawValid = 0;
    step(1'b1, 1'b0, 1'b1, 8'h11);
    for (int t = 0; t < 6; t++) begin
      step(1'b0, 1'b0, (t >= 3) ? 1'b0 : 1'b1, 8'h12);
      sawStrobe += int'(wrStrobe); sawOe += int'(outEn); sawValid += int'(typeValid);
    end
    check(sawOe == 0 && sawValid == 0, "R8", "CAS-first outEn/valid cycles", sawOe + sawValid, 0);
    check(sawStrobe == 0, "R8", "CAS-first write strobes", sawStrobe, 0);
    step(1'b1, 1'b1, 1'b1, 8'h00);
    step(1'b1, 1'b1, 1'b1, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule